// File: doc/BRIEF.md
# Register-to-Register Integer Execute Unit

This block executes three arithmetic instructions against a 32-entry, 32-bit register file: register add, register subtract and add-with-immediate. Each cycle it may receive one 32-bit instruction word, qualified by a valid strobe. It splits the word into its fields and reads two source registers. It then forms the sum or difference and stores the result on the next rising clock edge. The whole read, compute and write sequence completes in one cycle.

There is no subtract-with-constant instruction. Software subtracts a constant by passing a negative immediate to add-immediate, so the 16-bit immediate is sign-extended before the addition. Register 0 is a constant zero. A word the unit does not recognise raises an illegal flag and leaves every register unchanged. A combinational debug read port shows any register's contents, so the register file can be inspected from outside.

The unit has no multi-cycle behaviour. Each accepted instruction passes through one decode, execute and write-back step. There is therefore no sequencing state, and the only clocked storage is the register file itself.

Top module: `regexec_unit`

## Requirements
- R1: A synchronous active-high reset sets all 32 registers to zero. From the cycle after reset, every debug read returns 0.
- R2: A valid word with bits 31:26 = 000000 and bits 5:0 = 100000 is a register add. It writes (reg[25:21] + reg[20:16]) mod 2^32 into the register numbered by bits 15:11.
- R3: A valid word with bits 31:26 = 000000 and bits 5:0 = 100010 is a register subtract. It writes (reg[25:21] - reg[20:16]) mod 2^32 into register bits 15:11. No overflow trap is raised.
- R4: A valid word with bits 31:26 = 001000 is add-immediate. It writes reg[25:21] plus bits 15:0 sign-extended to 32 bits into the register numbered by bits 20:16. A negative immediate therefore performs a subtraction.
- R5: Register 0 always reads as zero, on the debug port and as an operand. A write aimed at it is discarded.
- R6: A valid word with any other opcode, or with opcode 000000 and any other function code, drives `illegal_op` high in the same cycle and writes no register.
- R7: When `in_valid` is low, no register changes and `illegal_op` stays low, whatever `insn` holds.
- R8: A written value appears on `dbg_data` for its register from the cycle after the writing edge.
- R9: Bits 10:6 of a register-form word have no effect on the result.
- R10: Operands are read before the edge. An instruction whose destination is also a source uses that register's old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word |
| illegal_op | output | 1 | Valid word not recognised (combinational) |
| dbg_idx | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Contents of register `dbg_idx` (combinational) |

## Verification
The assertions assume three things about the inputs. First, `insn` and `in_valid` are settled before each rising edge and stay constant across it. Second, reset is applied before the first instruction. Third, `dbg_idx` may change between edges. The stimulus respects this by changing `insn` and `in_valid` only just after a falling edge and by releasing reset on a falling edge. It reads the register file through `dbg_idx` only while `in_valid` is low, so no debug sweep overlaps an accepted instruction. The instruction mix covers destination register 0, operands that wrap in both directions, negative and extreme immediates, nonzero bits 10:6, unknown opcodes and unknown function codes.

// File: rtl/regexec_pkg.sv
package regexec_pkg;
    localparam int XLEN    = 32;
    localparam int AW      = 5;
    localparam int NREG    = 1 << AW;
    localparam int IMM_W   = 16;
    localparam int CODE_W  = 6;

    localparam logic [CODE_W-1:0] OPC_REGFORM = 6'b000000;
    localparam logic [CODE_W-1:0] OPC_ADDIMM  = 6'b001000;
    localparam logic [CODE_W-1:0] FN_ADD      = 6'b100000;
    localparam logic [CODE_W-1:0] FN_SUB      = 6'b100010;

    typedef enum logic [1:0] {
        K_ADD,
        K_SUB,
        K_ADDIMM,
        K_BAD
    } op_kind_e;

    typedef struct packed {
        logic [CODE_W-1:0] opc;
        logic [AW-1:0]     src_a;
        logic [AW-1:0]     src_b;
        logic [AW-1:0]     dst;
        logic [AW-1:0]     shift;
        logic [CODE_W-1:0] fn;
    } word_fields_t;
endpackage

// File: rtl/regexec_decode.sv
module regexec_decode
    import regexec_pkg::*;
(
    input  logic            in_valid,
    input  logic [31:0]     insn,
    output op_kind_e        kind,
    output logic [AW-1:0]   rs_idx,
    output logic [AW-1:0]   rt_idx,
    output logic [AW-1:0]   dst_idx,
    output logic [XLEN-1:0] imm_ext,
    output logic            wr_en,
    output logic            illegal
);
    word_fields_t f;
    assign f = word_fields_t'(insn);

    always_comb begin
        kind = K_BAD;
        unique case (f.opc)
            OPC_REGFORM: begin
                if (f.fn == FN_ADD)      kind = K_ADD;
                else if (f.fn == FN_SUB) kind = K_SUB;
                else                     kind = K_BAD;
            end
            OPC_ADDIMM: kind = K_ADDIMM;
            default:    kind = K_BAD;
        endcase
    end

    assign rs_idx  = f.src_a;
    assign rt_idx  = f.src_b;
    assign dst_idx = (kind == K_ADDIMM) ? f.src_b : f.dst;
    assign imm_ext = {{(XLEN-IMM_W){insn[IMM_W-1]}}, insn[IMM_W-1:0]};
    assign wr_en   = in_valid && (kind != K_BAD);
    assign illegal = in_valid && (kind == K_BAD);
endmodule

// File: rtl/regexec_alu.sv
module regexec_alu
    import regexec_pkg::*;
(
    input  op_kind_e        kind,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b_reg,
    input  logic [XLEN-1:0] b_imm,
    output logic [XLEN-1:0] result
);
    logic [XLEN-1:0] b;

    always_comb begin
        b = (kind == K_ADDIMM) ? b_imm : b_reg;
        unique case (kind)
            K_SUB:   result = a - b;
            default: result = a + b;
        endcase
    end
endmodule

// File: rtl/regexec_regfile.sv
module regexec_regfile
    import regexec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   w_idx,
    input  logic [XLEN-1:0] w_data,
    input  logic [AW-1:0]   ra_idx,
    output logic [XLEN-1:0] ra_data,
    input  logic [AW-1:0]   rb_idx,
    output logic [XLEN-1:0] rb_data,
    input  logic [AW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_data
);
    logic [XLEN-1:0] cells [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) cells[i] <= '0;
        end else if (we && (w_idx != '0)) begin
            cells[w_idx] <= w_data;
        end
    end

    assign ra_data = (ra_idx == '0) ? '0 : cells[ra_idx];
    assign rb_data = (rb_idx == '0) ? '0 : cells[rb_idx];
    assign rd_data = (rd_idx == '0) ? '0 : cells[rd_idx];
endmodule

// File: rtl/regexec_unit.sv
module regexec_unit
    import regexec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    output logic            illegal_op,
    input  logic [AW-1:0]   dbg_idx,
    output logic [XLEN-1:0] dbg_data
);
    op_kind_e        kind;
    logic [AW-1:0]   rs_idx;
    logic [AW-1:0]   rt_idx;
    logic [AW-1:0]   wr_idx;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] wr_data;
    logic            wr_en;

    regexec_decode i_decode (
        .in_valid (in_valid),
        .insn     (insn),
        .kind     (kind),
        .rs_idx   (rs_idx),
        .rt_idx   (rt_idx),
        .dst_idx  (wr_idx),
        .imm_ext  (imm_ext),
        .wr_en    (wr_en),
        .illegal  (illegal_op)
    );

    regexec_regfile i_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .w_idx   (wr_idx),
        .w_data  (wr_data),
        .ra_idx  (rs_idx),
        .ra_data (rs_val),
        .rb_idx  (rt_idx),
        .rb_data (rt_val),
        .rd_idx  (dbg_idx),
        .rd_data (dbg_data)
    );

    regexec_alu i_alu (
        .kind   (kind),
        .a      (rs_val),
        .b_reg  (rt_val),
        .b_imm  (imm_ext),
        .result (wr_data)
    );
endmodule

// File: rtl/regexec_chk.sv
module regexec_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] insn,
    input logic        illegal_op,
    input logic [4:0]  dbg_idx,
    input logic [31:0] dbg_data,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val
);
    logic is_add, is_sub, is_addi;
    assign is_add  = in_valid && insn[31:26] == 6'b000000 && insn[5:0] == 6'b100000;
    assign is_sub  = in_valid && insn[31:26] == 6'b000000 && insn[5:0] == 6'b100010;
    assign is_addi = in_valid && insn[31:26] == 6'b001000;

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> dbg_data == 32'd0);

    assert_add_result_R2: assert property (@(posedge clk) disable iff (rst)
        is_add |-> (wr_en && wr_idx == insn[15:11] && wr_data == rs_val + rt_val));

    assert_sub_result_R3: assert property (@(posedge clk) disable iff (rst)
        is_sub |-> (wr_en && wr_idx == insn[15:11] && wr_data == rs_val - rt_val));

    assert_addimm_result_R4: assert property (@(posedge clk) disable iff (rst)
        is_addi |-> (wr_en && wr_idx == insn[20:16] &&
                     wr_data == rs_val + {{16{insn[15]}}, insn[15:0]}));

    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (rst)
        dbg_idx == 5'd0 |-> dbg_data == 32'd0);

    assert_illegal_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> !wr_en);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> (!illegal_op && !wr_en));

    assert_write_visible_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != 5'd0 && wr_idx == dbg_idx) |=>
            (dbg_idx != $past(dbg_idx) || dbg_data == $past(wr_data)));
endmodule

bind regexec_unit regexec_chk i_regexec_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .insn       (insn),
    .illegal_op (illegal_op),
    .dbg_idx    (dbg_idx),
    .dbg_data   (dbg_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rs_val     (rs_val),
    .rt_val     (rt_val)
);

// File: tb/test_regexec_unit.sv
`timescale 1ns/1ps
module test_regexec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] insn = 32'd0;
    logic        illegal_op;
    logic [4:0]  dbg_idx = 5'd0;
    logic [31:0] dbg_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] mdl [32];

    always #4 clk = ~clk;

    regexec_unit i_regexec_unit (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .insn       (insn),
        .illegal_op (illegal_op),
        .dbg_idx    (dbg_idx),
        .dbg_data   (dbg_data)
    );

    function automatic logic [31:0] w_reg(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn, input int sh);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction

    function automatic logic [31:0] w_imm(input logic [5:0] opc, input int rs,
                                          input int rt, input logic [15:0] imm);
        return {opc, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req,
                       input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 32; i++) begin
            dbg_idx = 5'(i);
            #0.05;
            chk(dbg_data, mdl[i], req, $sformatf("reg %0d", i));
        end
    endtask

    task automatic run(input logic [31:0] w, input logic v, input string req);
        logic [5:0]  opc, fn;
        logic [31:0] a, b, res;
        int          dst;
        bit          known;
        opc = w[31:26];
        fn  = w[5:0];
        a   = mdl[w[25:21]];
        b   = mdl[w[20:16]];
        known = 1'b1;
        dst = int'(w[15:11]);
        if (opc == 6'b000000 && fn == 6'b100000) res = a + b;
        else if (opc == 6'b000000 && fn == 6'b100010) res = a - b;
        else if (opc == 6'b001000) begin
            res = a + {{16{w[15]}}, w[15:0]};
            dst = int'(w[20:16]);
        end else begin
            known = 1'b0;
            res = 32'd0;
        end
        @(negedge clk);
        insn = w;
        in_valid = v;
        #1;
        chk({31'd0, illegal_op}, {31'd0, v && !known}, v ? (known ? req : "R6") : "R7",
            "illegal_op");
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        if (v && known && dst != 0) mdl[dst] = res;
        sweep(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) mdl[i] = 32'd0;
        #1;
        sweep("R1");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        sweep("R1");

        run(w_imm(6'b001000, 0, 1, 16'd5), 1'b1, "R4");
        run(w_imm(6'b001000, 0, 2, 16'hFFFD), 1'b1, "R4");
        run(w_reg(1, 2, 3, 6'b100000, 0), 1'b1, "R2");
        run(w_reg(2, 1, 4, 6'b100010, 0), 1'b1, "R3");
        run(w_imm(6'b001000, 0, 5, 16'h7FFF), 1'b1, "R4");
        run(w_imm(6'b001000, 0, 6, 16'h8000), 1'b1, "R4");
        run(w_imm(6'b001000, 0, 7, 16'hFFFF), 1'b1, "R4");
        run(w_imm(6'b001000, 0, 8, 16'd1), 1'b1, "R4");
        run(w_reg(7, 8, 9, 6'b100000, 0), 1'b1, "R2");
        run(w_reg(0, 8, 10, 6'b100010, 0), 1'b1, "R3");
        run(w_reg(6, 5, 11, 6'b100010, 0), 1'b1, "R3");
        run(w_imm(6'b001000, 1, 0, 16'd7), 1'b1, "R5");
        run(w_reg(1, 1, 0, 6'b100000, 0), 1'b1, "R5");
        run(w_reg(1, 2, 12, 6'b100001, 0), 1'b1, "R6");
        run(w_imm(6'b100011, 1, 13, 16'd4), 1'b1, "R6");
        run(w_reg(1, 2, 14, 6'b000000, 0), 1'b1, "R6");
        run(w_reg(1, 2, 15, 6'b100000, 0), 1'b0, "R7");
        run(w_imm(6'b111111, 1, 16, 16'd4), 1'b0, "R7");
        run(w_reg(1, 1, 1, 6'b100000, 0), 1'b1, "R10");
        run(w_reg(3, 1, 3, 6'b100010, 0), 1'b1, "R10");
        run(w_reg(1, 2, 17, 6'b100000, 31), 1'b1, "R9");
        run(w_reg(1, 2, 18, 6'b100010, 9), 1'b1, "R9");
        run(w_imm(6'b001000, 17, 19, 16'h1234), 1'b1, "R8");

        for (int k = 0; k < 200; k++) begin
            int sel, ra, rb, rd;
            sel = int'($urandom_range(0, 5));
            ra  = int'($urandom_range(0, 31));
            rb  = int'($urandom_range(0, 31));
            rd  = int'($urandom_range(0, 31));
            case (sel)
                0: run(w_reg(ra, rb, rd, 6'b100000, int'($urandom_range(0, 31))), 1'b1, "R2");
                1: run(w_reg(ra, rb, rd, 6'b100010, int'($urandom_range(0, 31))), 1'b1, "R3");
                2: run(w_imm(6'b001000, ra, rb, 16'($urandom)), 1'b1, "R4");
                3: run(w_imm(6'($urandom_range(9, 63)), ra, rb, 16'($urandom)), 1'b1, "R6");
                4: run(w_reg(ra, rb, rd, 6'($urandom_range(33, 63)), 0), 1'b1, "R6");
                default: run(w_reg(ra, rb, rd, 6'b100000, 0), 1'b0, "R7");
            endcase
        end

        do_reset();
        run(w_imm(6'b001000, 0, 20, 16'hFF00), 1'b1, "R4");
        summary();
    end
endmodule